// File: doc/BRIEF.md
# Half-Bridge Rectifier Drive Sequencer

This block sits between the pulse-width modulator of a half-bridge converter and its gate drivers. Once per oscillator cycle it receives a boundary strobe, and within each cycle a request that stays high while the modulator wants the primary switch conducting. From these it produces four gate commands: a low-side primary drive, a high-side primary drive, and one synchronous-rectifier drive for each leg. The two primary switches take alternate cycles, so one full bridge period covers two oscillator cycles. The first pulse after the block is started always goes to the low side, which charges the bootstrap supply of the high side first.

The rectifier drives are interlocked with the primaries. A rectifier drive sits high, meaning that rectifier conducts, whenever its leg is idle. Before the primary of a leg turns on, that leg's rectifier drive is pulled low. The primary then waits a programmed number of clock ticks. After the primary turns off, the rectifier drive stays low for a second programmed delay. If that second delay would run past the next cycle boundary, it is cut short at the boundary. A high-side inhibit input suppresses the high-side pulses and leaves the low-side sequencing untouched. Dropping the run enable returns all four drives to their safe levels on the next clock.

Top module: `hb_sr_sequencer`

## Requirements
- R1: While reset is asserted and after it, before any start, both primary drives are 0 and both rectifier drives are 1.
- R2: After run_en rises, the first accepted boundary strobe opens a low-side cycle. Every later strobe switches the cycle to the other leg.
- R3: In a cycle with no pulse yet, a pwm_req sampled high drives the active leg's rectifier low on that clock edge. The primary of that leg rises pre_dly+1 clocks after the rectifier falls (pre_dly = 0 gives one clock).
- R4: The primary stays high while pwm_req is sampled high. It falls on the edge where pwm_req is sampled low, so it is high for at least one clock. The two primary drives are never high together.
- R5: After the primary falls, the rectifier of that leg returns high post_dly+1 clocks later, unless a boundary comes first.
- R6: A boundary strobe that arrives while a rectifier is still in its post-off delay drives that rectifier high on the strobe's edge.
- R7: At most one pulse is issued per cycle. A pwm_req after the pulse has completed is ignored until the next strobe.
- R8: With hs_inhibit high when a high-side request arrives, no high-side pulse is issued and both rectifiers stay high for that cycle. Low-side cycles are unaffected by hs_inhibit.
- R9: With run_en sampled low, both primary drives are 0 and both rectifier drives are 1 from the next edge onward. Strobes and requests are ignored. The next start begins on the low side.
- R10: A strobe that arrives while a primary is on turns that primary off on the strobe's edge. Its rectifier stays low for one more clock and then returns high. The cycle has then passed to the other leg.
- R11: Outside the window from a leg's rectifier fall to its rectifier return, both rectifier drives are 1 and both primary drives are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low forces the safe drive state |
| cyc_strobe | input | 1 | One-clock oscillator cycle boundary marker |
| pwm_req | input | 1 | Primary on-request from the modulator |
| hs_inhibit | input | 1 | Suppresses high-side pulses |
| pre_dly | input | DLY_W | Ticks between rectifier off and primary on, minus one |
| post_dly | input | DLY_W | Ticks between primary off and rectifier on, minus one |
| drv_lo | output | 1 | Low-side primary gate command |
| drv_hi | output | 1 | High-side primary gate command |
| sr_lo | output | 1 | Low-leg rectifier drive (1 = rectifier on) |
| sr_hi | output | 1 | High-leg rectifier drive (1 = rectifier on) |

## Verification
The bench builds the block with the default DLY_W of 4 and sweeps pre_dly from 0 to 3, post_dly from 0 to 5 and on-request lengths of 1 to 3 clocks, each on both legs with the inhibit off and on. It runs that sweep with two cycle lengths, 16 and 10 clocks. The short cycle makes longer post-off delays cross the boundary, so the truncation path is reached alongside the untruncated one. Directed sequences add a strobe that lands during a primary pulse, a run-enable drop during a pulse followed by a restart, and repeat requests after a completed pulse.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_PRE   = 3'd2,
        ST_ON    = 3'd3,
        ST_POST  = 3'd4,
        ST_DONE  = 3'd5,
        ST_CUT   = 3'd6
    } seq_st_e;

    typedef enum logic {
        LEG_LO = 1'b0,
        LEG_HI = 1'b1
    } leg_e;

    typedef struct packed {
        logic pri;
        logic sr;
    } gate_t;

    localparam gate_t GATE_SAFE = '{pri: 1'b0, sr: 1'b1};

    function automatic leg_e other_leg(leg_e l);
        return (l == LEG_LO) ? LEG_HI : LEG_LO;
    endfunction

    // rectifier of the owning leg is held off in these states
    function automatic logic in_window(seq_st_e s);
        return (s == ST_PRE) || (s == ST_ON) || (s == ST_POST) || (s == ST_CUT);
    endfunction

    function automatic gate_t leg_gate(seq_st_e s, leg_e owner, leg_e leg);
        gate_t g;
        g = GATE_SAFE;
        if (owner == leg) begin
            g.pri = (s == ST_ON);
            g.sr  = !in_window(s);
        end
        return g;
    endfunction

endpackage

// File: rtl/hbs_bbm_timer.sv
module hbs_bbm_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hbs_seq_fsm.sv
module hbs_seq_fsm
    import hbs_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         cyc_strobe,
    input  logic         pwm_req,
    input  logic         hs_inhibit,
    input  logic [W-1:0] pre_dly,
    input  logic [W-1:0] post_dly,
    output seq_st_e      st_nxt,
    output leg_e         side_nxt
);
    seq_st_e      st, st_n;
    leg_e         side, side_n;
    logic         ld;
    logic [W-1:0] ld_val;
    logic         expired;

    hbs_bbm_timer #(.W(W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        st_n   = st;
        side_n = side;
        ld     = 1'b0;
        ld_val = pre_dly;
        if (!run_en) begin
            st_n   = ST_IDLE;
            side_n = LEG_LO;
        end else if (cyc_strobe) begin
            case (st)
                ST_IDLE: begin
                    st_n   = ST_ARMED;
                    side_n = LEG_LO;
                end
                ST_ON:   st_n = ST_CUT;
                default: begin
                    st_n   = ST_ARMED;
                    side_n = other_leg(side);
                end
            endcase
        end else begin
            case (st)
                ST_ARMED: begin
                    if (pwm_req && !(side == LEG_HI && hs_inhibit)) begin
                        st_n   = ST_PRE;
                        ld     = 1'b1;
                        ld_val = pre_dly;
                    end
                end
                ST_PRE: begin
                    if (expired)
                        st_n = ST_ON;
                end
                ST_ON: begin
                    if (!pwm_req) begin
                        st_n   = ST_POST;
                        ld     = 1'b1;
                        ld_val = post_dly;
                    end
                end
                ST_POST: begin
                    if (expired)
                        st_n = ST_DONE;
                end
                ST_CUT: begin
                    st_n   = ST_ARMED;
                    side_n = other_leg(side);
                end
                default: st_n = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            side <= LEG_LO;
        end else begin
            st   <= st_n;
            side <= side_n;
        end
    end

    assign st_nxt   = st_n;
    assign side_nxt = side_n;

    // R2: a fresh start always opens on the low leg
    a_r2_first_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && run_en && cyc_strobe) |=> (side == LEG_LO));

    // R2: boundaries hand the cycle to the other leg
    a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
        (run_en && cyc_strobe &&
         (st == ST_ARMED || st == ST_PRE || st == ST_POST || st == ST_DONE || st == ST_CUT))
        |=> (side != $past(side)));

    // R10: a cut pulse passes the cycle on one clock later
    a_r10_cut_handover: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CUT && run_en) |=> (st == ST_ARMED && side != $past(side)));

    // R7: a finished cycle stays finished until a boundary
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && run_en && !cyc_strobe) |=> (st == ST_DONE));

endmodule

// File: rtl/hbs_leg_drive.sv
module hbs_leg_drive
    import hbs_pkg::*;
#(
    parameter leg_e LEG = LEG_LO
) (
    input  logic    clk,
    input  logic    rst,
    input  seq_st_e st_nxt,
    input  leg_e    side_nxt,
    output logic    pri,
    output logic    sr
);
    gate_t g_q;

    always_ff @(posedge clk) begin
        if (rst)
            g_q <= GATE_SAFE;
        else
            g_q <= leg_gate(st_nxt, side_nxt, LEG);
    end

    assign pri = g_q.pri;
    assign sr  = g_q.sr;

    // R3: the rectifier is already off one clock before its primary rises
    a_r3_sr_leads_pri: assert property (@(posedge clk) disable iff (rst)
        $rose(pri) |-> !$past(sr));

endmodule

// File: rtl/hb_sr_sequencer.sv
module hb_sr_sequencer
    import hbs_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             cyc_strobe,
    input  logic             pwm_req,
    input  logic             hs_inhibit,
    input  logic [DLY_W-1:0] pre_dly,
    input  logic [DLY_W-1:0] post_dly,
    output logic             drv_lo,
    output logic             drv_hi,
    output logic             sr_lo,
    output logic             sr_hi
);
    localparam int NLEG = 2;

    seq_st_e         st_nxt;
    leg_e            side_nxt;
    logic [NLEG-1:0] pri_v;
    logic [NLEG-1:0] sr_v;

    hbs_seq_fsm #(.W(DLY_W)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .cyc_strobe (cyc_strobe),
        .pwm_req    (pwm_req),
        .hs_inhibit (hs_inhibit),
        .pre_dly    (pre_dly),
        .post_dly   (post_dly),
        .st_nxt     (st_nxt),
        .side_nxt   (side_nxt)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hbs_leg_drive #(.LEG((g == 0) ? LEG_LO : LEG_HI)) i_leg (
            .clk      (clk),
            .rst      (rst),
            .st_nxt   (st_nxt),
            .side_nxt (side_nxt),
            .pri      (pri_v[g]),
            .sr       (sr_v[g])
        );
    end

    assign drv_lo = pri_v[0];
    assign drv_hi = pri_v[1];
    assign sr_lo  = sr_v[0];
    assign sr_hi  = sr_v[1];

    // R4: the bridge never conducts through both primaries
    a_r4_pri_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_lo && drv_hi));

    // R9: disable parks every drive at its safe level
    a_r9_disable_safe: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!drv_lo && !drv_hi && sr_lo && sr_hi));

    // R5: the rectifier is still off when its primary releases
    a_r5_lo_sr_trails: assert property (@(posedge clk) disable iff (rst)
        ($fell(drv_lo) && $past(run_en)) |-> !sr_lo);
    a_r5_hi_sr_trails: assert property (@(posedge clk) disable iff (rst)
        ($fell(drv_hi) && $past(run_en)) |-> !sr_hi);

endmodule

// File: tb/test_hb_sr_sequencer.sv
`timescale 1ns/1ps
module test_hb_sr_sequencer;

    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_en = 1'b0;
    logic             cyc_strobe = 1'b0;
    logic             pwm_req = 1'b0;
    logic             hs_inhibit = 1'b0;
    logic [DLY_W-1:0] pre_dly = '0;
    logic [DLY_W-1:0] post_dly = '0;
    logic             drv_lo, drv_hi, sr_lo, sr_hi;

    int  vec_cnt = 0;
    int  bad_cnt = 0;
    bit  finished = 1'b0;
    bit  trunc_pending = 1'b0;

    always #2 clk = ~clk;

    hb_sr_sequencer #(.DLY_W(DLY_W)) i_hb_sr_sequencer (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .cyc_strobe (cyc_strobe),
        .pwm_req    (pwm_req),
        .hs_inhibit (hs_inhibit),
        .pre_dly    (pre_dly),
        .post_dly   (post_dly),
        .drv_lo     (drv_lo),
        .drv_hi     (drv_hi),
        .sr_lo      (sr_lo),
        .sr_hi      (sr_hi)
    );

    // output order in every vector: {drv_lo, drv_hi, sr_lo, sr_hi}
    task automatic compare(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {drv_lo, drv_hi, sr_lo, sr_hi};
        vec_cnt++;
        if (got !== exp) begin
            bad_cnt++;
            $display("FAIL %s: got %b expected %b (drv_lo drv_hi sr_lo sr_hi)", tag, got, exp);
        end
    endtask

    // called at a falling edge; drives inputs, passes one rising edge, checks
    task automatic step(input logic en, input logic stb, input logic pw, input logic ih,
                        input logic [3:0] exp, input string tag);
        run_en     = en;
        cyc_strobe = stb;
        pwm_req    = pw;
        hs_inhibit = ih;
        @(posedge clk);
        @(negedge clk);
        compare(exp, tag);
    endtask

    task automatic restart();
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b0011, "R9");
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0011, "R9");
        trunc_pending = 1'b0;
    endtask

    // one oscillator cycle of length len, strobe on its first edge
    task automatic run_cycle(input int s, input int ih, input int pre, input int post,
                             input int onl, input int len);
        int  ton, toff, full, srend;
        bit  act;
        ton   = pre + 2;
        toff  = ton + onl;
        full  = toff + post + 1;
        srend = (full < len) ? full : len;
        act   = !(s == 1 && ih == 1);
        for (int t = 0; t < len; t++) begin
            logic pw, pri, srl;
            logic [3:0] exp;
            string tag;
            pw  = (t >= 1 && t < toff) || (t > srend && t < len - 1);
            pri = act && t >= ton && t < toff;
            srl = act && t >= 1 && t < srend;
            exp = {(s == 0) && pri, (s == 1) && pri, !((s == 0) && srl), !((s == 1) && srl)};
            if (t == 0 && trunc_pending)   tag = "R6";
            else if (!act)                 tag = "R8";
            else if (t == ton)             tag = "R2";
            else if (t < ton && t >= 1)    tag = "R3";
            else if (t > ton && t < toff)  tag = "R4";
            else if (t >= toff && t < srend) tag = "R5";
            else if (t > srend)            tag = "R7";
            else                           tag = "R11";
            step(1'b1, (t == 0), pw, ih[0], exp, tag);
        end
        trunc_pending = act && (full > len);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(4'b0011, "R1");
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b0011, "R1");

        // timing sweep, both legs, inhibit off/on, long and short cycles
        for (int li = 0; li < 2; li++) begin
            int len;
            len = (li == 0) ? 16 : 10;
            for (int ih = 0; ih < 2; ih++)
                for (int pre = 0; pre < 4; pre++)
                    for (int post = 0; post < 6; post++)
                        for (int onl = 1; onl < 4; onl++) begin
                            if (pre + 2 + onl <= len - 1) begin
                                pre_dly  = DLY_W'(pre);
                                post_dly = DLY_W'(post);
                                restart();
                                run_cycle(0, ih, pre, post, onl, len);
                                run_cycle(1, ih, pre, post, onl, len);
                            end
                        end
        end

        // R10: boundary lands while the low-side primary is on
        pre_dly  = '0;
        post_dly = DLY_W'(2);
        restart();
        for (int t = 0; t < 10; t++) begin
            logic [3:0] exp;
            exp = {(t >= 2), 1'b0, !(t >= 1), 1'b1};
            step(1'b1, (t == 0), (t >= 1), 1'b0, exp, "R10");
        end
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'b0001, "R10");
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0011, "R10");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0010, "R10");

        // R9: enable dropped mid-pulse, then restart on the low side
        restart();
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0011, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b1001, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'b0011, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, 4'b0011, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0011, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0001, "R9");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad_cnt++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

endmodule